// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which of four DMA channels may move its next transfer unit when several of them want the bus at once. A two-bit mode input picks the ordering rule. Three codes give fixed orders that never change. The fourth code gives a rotating order: after each completed unit, the channel just served drops to the back of the queue.

A grant is taken only between units. Once a grant is issued it is held until the datapath signals that the unit is complete on that same channel, so no unit is ever preempted. Each channel takes its request from one of two sources:
- a direct request line, which the block never clears;
- a latched peripheral request, which the block clears by itself. In cycle-steal mode the clear comes with the first completed unit; in burst mode it comes with the unit flagged as the last one.

While a channel is routed to its peripheral, the block also raises a mask bit so that the peripheral's event does not reach the CPU as an interrupt.

The controller has two states:
- ST_IDLE, the arbitration point: no grant is driven.
- ST_BUSY: one grant is driven and held.

It has three transitions:
- ST_IDLE to ST_BUSY, taken when any effective request is present; the winner is latched.
- ST_BUSY to ST_IDLE, taken on an accepted unit-done strobe.
- ST_BUSY to itself, on every other cycle.

The rotating order lives in its own register and changes only on an accepted unit-done strobe while the mode is rotating.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset the grant is 4'b0000, grant_vld is 0, grant_ch is 0, and the rotating order is CH0 first, then CH1, CH2, CH3.
- R2: The grant is one-hot or all zeros. grant_vld is 1 exactly when a grant is driven, and then grant_ch holds the index of the set bit. Only a channel whose effective request was present at the arbitration point is granted, and with no effective request the grant stays all zeros.
- R3: Mode code 2'b00 ranks the channels CH0 > CH1 > CH2 > CH3.
- R4: Mode code 2'b01 ranks the channels CH0 > CH2 > CH3 > CH1.
- R5: Mode code 2'b10 ranks the channels CH2 > CH0 > CH1 > CH3.
- R6: In mode code 2'b11, each accepted unit-done strobe on channel c moves c to the lowest rank. The other channels keep their relative order.
- R7: The rotating order does not change on cycles without an accepted unit-done strobe. It returns to CH0 > CH1 > CH2 > CH3 on any cycle in which the mode code is not 2'b11.
- R8: A driven grant is held until unit_done is 1 with unit_ch equal to grant_ch. The following have no effect on the grant:
  - higher-ranked requests;
  - mode changes;
  - a unit_done whose index does not match;
  - a unit_done given while no grant is driven.
  A mode change takes effect at the next arbitration point.
- R9: A request present while idle is granted at the next clock edge. After an accepted unit-done strobe the grant is zero for exactly one cycle, and then arbitration repeats.
- R10: irq_mask[i] is 1 exactly when per_route[i] is 1.
- R11: A channel with per_route[i]=1 latches a pending request on per_irq[i]. With burst_sel[i]=0 (cycle steal), that pending request is cleared by the first accepted unit-done on channel i.
- R12: With burst_sel[i]=1 (burst), the pending peripheral request is cleared only by an accepted unit-done on channel i with unit_last=1. Otherwise the channel requests again.
- R13: A channel with per_route[i]=0 requests exactly when sw_req[i] is 1, and the block never clears that request. A channel with per_route[i]=1 ignores sw_req[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Priority mode: 00, 01 and 10 select the fixed orders, 11 selects rotating |
| sw_req | input | 4 | Direct per-channel request lines |
| per_route | input | 4 | 1 = channel takes its request from its peripheral |
| per_irq | input | 4 | Peripheral request event, sampled each cycle |
| burst_sel | input | 4 | 1 = burst, 0 = cycle steal, per channel |
| unit_done | input | 1 | One transfer unit has completed |
| unit_ch | input | 2 | Channel that completed the unit |
| unit_last | input | 1 | The completed unit was the last one of the block |
| grant | output | 4 | One-hot grant |
| grant_ch | output | 2 | Index of the granted channel (0 when idle) |
| grant_vld | output | 1 | A grant is driven |
| irq_mask | output | 4 | Per-channel CPU interrupt suppression |

## Verification
The assertions check four properties on every cycle:
- the grant is one-hot or zero;
- a grant is held until a matching completion, and drops right after one;
- no grant is given to a channel that did not request;
- under modes 00, 01 and 10, the top-ranked requester wins.

Other behaviours can only be shown by the bench's scenarios, because each one depends on a history of requests and completions:
- the rotation of the order over many units;
- the reset of the order when the mode leaves 11;
- the automatic clearing of peripheral requests in cycle-steal and burst modes;
- the rejection of mismatched or idle completions.

The bench sweeps every request pattern under each mode against an order model of its own.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int NCH = 4;
    localparam int CW  = $clog2(NCH);

    typedef logic [CW-1:0] ch_t;
    // rank 0 is the highest priority
    typedef ch_t [NCH-1:0] order_t;

    typedef enum logic [1:0] {
        MODE_FIX_A = 2'b00,
        MODE_FIX_B = 2'b01,
        MODE_FIX_C = 2'b10,
        MODE_ROT   = 2'b11
    } mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_state_e;

    function automatic order_t base_order();
        order_t o;
        for (int k = 0; k < NCH; k++) begin
            o[k] = CW'(k);
        end
        return o;
    endfunction

    function automatic order_t fixed_order(input logic [1:0] m);
        order_t o;
        unique case (m)
            2'b01:   o = {2'd1, 2'd3, 2'd2, 2'd0};
            2'b10:   o = {2'd3, 2'd1, 2'd0, 2'd2};
            default: o = base_order();
        endcase
        return o;
    endfunction

endpackage

// File: rtl/dma_rr_order.sv
module dma_rr_order
    import dma_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rot_en,
    input  logic   adv,
    input  ch_t    adv_ch,
    output order_t ord_q
);

    order_t ord_d;
    order_t rot;
    ch_t    pos;

    always_comb begin
        pos = '0;
        for (int k = 0; k < NCH; k++) begin
            if (ord_q[k] == adv_ch) begin
                pos = CW'(k);
            end
        end
        rot = ord_q;
        for (int k = 0; k < NCH - 1; k++) begin
            if (k >= int'(pos)) begin
                rot[k] = ord_q[k+1];
            end
        end
        rot[NCH-1] = adv_ch;
    end

    always_comb begin
        if (!rot_en) begin
            ord_d = base_order();
        end else if (adv) begin
            ord_d = rot;
        end else begin
            ord_d = ord_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ord_q <= base_order();
        end else begin
            ord_q <= ord_d;
        end
    end

endmodule

// File: rtl/dma_req_src.sv
module dma_req_src
    import dma_arb_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sw_req,
    input  logic [NCH-1:0] per_route,
    input  logic [NCH-1:0] per_irq,
    input  logic [NCH-1:0] burst_sel,
    input  logic           done_acc,
    input  ch_t            done_ch,
    input  logic           done_last,
    output logic [NCH-1:0] req_eff,
    output logic [NCH-1:0] irq_mask
);

    logic [NCH-1:0] pend_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic clr;
        logic pend_d;

        always_comb begin
            clr = done_acc && (done_ch == CW'(i)) && (!burst_sel[i] || done_last);
            if (!per_route[i]) begin
                pend_d = 1'b0;
            end else begin
                pend_d = (pend_q[i] && !clr) || per_irq[i];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[i] <= 1'b0;
            end else begin
                pend_q[i] <= pend_d;
            end
        end

        assign req_eff[i]  = per_route[i] ? pend_q[i] : sw_req[i];
        assign irq_mask[i] = per_route[i];
    end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
    import dma_arb_pkg::*;
(
    input  order_t         ord,
    input  logic [NCH-1:0] req,
    output logic           hit,
    output ch_t            win
);

    always_comb begin
        hit = 1'b0;
        win = '0;
        for (int k = NCH - 1; k >= 0; k--) begin
            if (req[ord[k]]) begin
                hit = 1'b1;
                win = ord[k];
            end
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           mode_sel,
    input  logic [NCH-1:0]       sw_req,
    input  logic [NCH-1:0]       per_route,
    input  logic [NCH-1:0]       per_irq,
    input  logic [NCH-1:0]       burst_sel,
    input  logic                 unit_done,
    input  logic [CW-1:0]        unit_ch,
    input  logic                 unit_last,
    output logic [NCH-1:0]       grant,
    output logic [CW-1:0]        grant_ch,
    output logic                 grant_vld,
    output logic [NCH-1:0]       irq_mask
);

    arb_state_e     state_q, state_d;
    ch_t            gch_q, gch_d;
    logic [NCH-1:0] req_eff;
    logic           done_acc;
    logic           rot_en;
    order_t         rr_ord;
    order_t         act_ord;
    logic           hit;
    ch_t            win;

    assign done_acc = (state_q == ST_BUSY) && unit_done && (unit_ch == gch_q);
    assign rot_en   = (mode_e'(mode_sel) == MODE_ROT);
    assign act_ord  = rot_en ? rr_ord : fixed_order(mode_sel);

    dma_req_src u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_req    (sw_req),
        .per_route (per_route),
        .per_irq   (per_irq),
        .burst_sel (burst_sel),
        .done_acc  (done_acc),
        .done_ch   (gch_q),
        .done_last (unit_last),
        .req_eff   (req_eff),
        .irq_mask  (irq_mask)
    );

    dma_rr_order u_rr (
        .clk    (clk),
        .rst_n  (rst_n),
        .rot_en (rot_en),
        .adv    (done_acc),
        .adv_ch (gch_q),
        .ord_q  (rr_ord)
    );

    dma_prio_pick u_pick (
        .ord (act_ord),
        .req (req_eff),
        .hit (hit),
        .win (win)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        gch_d   = gch_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hit) begin
                    state_d = ST_BUSY;
                    gch_d   = win;
                end
            end
            ST_BUSY: begin
                if (done_acc) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gch_q   <= '0;
        end else begin
            state_q <= state_d;
            gch_q   <= gch_d;
        end
    end

    // outputs
    always_comb begin
        grant     = '0;
        grant_ch  = '0;
        grant_vld = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_BUSY: begin
                grant[gch_q] = 1'b1;
                grant_ch     = gch_q;
                grant_vld    = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk
    import dma_arb_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     mode_sel,
    input logic [NCH-1:0] sw_req,
    input logic [NCH-1:0] per_route,
    input logic           unit_done,
    input logic [CW-1:0]  unit_ch,
    input logic [NCH-1:0] grant,
    input logic [CW-1:0]  grant_ch
);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !(unit_done && unit_ch == grant_ch)) |=> $stable(grant));

    // R9
    grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && unit_done && unit_ch == grant_ch) |=> grant == '0);

    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && per_route == '0) |=> (grant & ~$past(sw_req)) == '0);

    // R3
    fix_a_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && mode_sel == 2'b00 && per_route == '0 && sw_req[0]) |=> grant == 4'b0001);

    // R4
    fix_b_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && mode_sel == 2'b01 && per_route == '0 && sw_req[0]) |=> grant == 4'b0001);

    // R5
    fix_c_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && mode_sel == 2'b10 && per_route == '0 && sw_req[2]) |=> grant == 4'b0100);

endmodule

bind dma_prio_arb dma_prio_arb_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .sw_req    (sw_req),
    .per_route (per_route),
    .unit_done (unit_done),
    .unit_ch   (unit_ch),
    .grant     (grant),
    .grant_ch  (grant_ch)
);

// File: tb/dma_prio_arb_tb.sv
`timescale 1ns/1ps
module dma_prio_arb_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic [3:0] sw_req, per_route, per_irq, burst_sel;
    logic       unit_done, unit_last;
    logic [1:0] unit_ch;
    logic [3:0] grant, irq_mask;
    logic [1:0] grant_ch;
    logic       grant_vld;

    int n_chk  = 0;
    int n_fail = 0;
    int rr[4];

    always #4 clk = ~clk;

    dma_prio_arb u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_req(sw_req),
        .per_route(per_route), .per_irq(per_irq), .burst_sel(burst_sel),
        .unit_done(unit_done), .unit_ch(unit_ch), .unit_last(unit_last),
        .grant(grant), .grant_ch(grant_ch), .grant_vld(grant_vld),
        .irq_mask(irq_mask)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_grant(input string req, input logic [3:0] exp);
        chk(grant == exp, req, int'(grant), int'(exp));
        if (exp != 4'b0000) begin
            chk(grant_vld && (4'b0001 << grant_ch) == exp, req, int'({grant_vld, 2'b00, grant_ch}), int'(exp));
        end else begin
            chk(!grant_vld, req, int'(grant_vld), 0);
        end
    endtask

    function automatic int rank_ch(input int m, input int r);
        int fa[4] = '{0, 1, 2, 3};
        int fb[4] = '{0, 2, 3, 1};
        int fc[4] = '{2, 0, 1, 3};
        case (m)
            0: return fa[r];
            1: return fb[r];
            2: return fc[r];
            default: return rr[r];
        endcase
    endfunction

    task automatic rr_move_last(input int c);
        int t[4];
        int j = 0;
        for (int k = 0; k < 4; k++) begin
            if (rr[k] != c) begin
                t[j] = rr[k];
                j++;
            end
        end
        t[3] = c;
        rr = t;
    endtask

    task automatic done_pulse(input logic [1:0] ch, input logic last);
        unit_done = 1'b1;
        unit_ch   = ch;
        unit_last = last;
        tick();
        unit_done = 1'b0;
        unit_last = 1'b0;
    endtask

    task automatic apply_vec(input int m, input logic [3:0] pat);
        int w = -1;
        string tag;
        for (int r = 3; r >= 0; r--) begin
            if (pat[rank_ch(m, r)]) w = rank_ch(m, r);
        end
        case (m)
            0: tag = "R3";
            1: tag = "R4";
            2: tag = "R5";
            default: tag = "R6";
        endcase
        sw_req = pat;
        tick();
        chk_grant(tag, (w >= 0) ? 4'(1 << w) : 4'b0000);
        if (w >= 0) begin
            done_pulse(2'(w), 1'b0);
            sw_req = '0;
            chk_grant("R9", 4'b0000);
            if (m == 3) rr_move_last(w);
        end else begin
            sw_req = '0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_sel = 2'b00; sw_req = '0; per_route = '0;
        per_irq = '0; burst_sel = '0; unit_done = 1'b0; unit_ch = '0; unit_last = 1'b0;
        repeat (3) tick();
        // R1 reset state
        chk_grant("R1", 4'b0000);
        chk(grant_ch == 2'd0, "R1", int'(grant_ch), 0);
        chk(irq_mask == 4'b0000, "R1", int'(irq_mask), 0);
        rst_n = 1'b1;
        tick();
        chk_grant("R1", 4'b0000);

        // R1 rotating order from reset: all request, mode 11
        mode_sel = 2'b11;
        for (int k = 0; k < 4; k++) rr[k] = k;
        apply_vec(3, 4'b1111);

        // sweep of all patterns under every mode
        for (int m = 0; m < 4; m++) begin
            mode_sel = 2'(m);
            for (int k = 0; k < 4; k++) rr[k] = k;
            tick();
            for (int rnd = 0; rnd < 3; rnd++) begin
                for (int p = 0; p < 16; p++) begin
                    apply_vec(m, 4'(p));
                end
            end
        end

        // R8: hold, no preemption, mismatched done, mode change mid-grant
        mode_sel = 2'b00; tick();
        sw_req = 4'b1000; tick();
        chk_grant("R8", 4'b1000);
        sw_req = 4'b1001; tick(); tick();
        chk_grant("R8", 4'b1000);
        done_pulse(2'd0, 1'b0);
        chk_grant("R8", 4'b1000);
        mode_sel = 2'b10; sw_req = 4'b0101; tick();
        chk_grant("R8", 4'b1000);
        done_pulse(2'd3, 1'b0);
        chk_grant("R9", 4'b0000);
        tick();
        chk_grant("R5", 4'b0100);
        done_pulse(2'd2, 1'b0);
        sw_req = '0; tick();

        // R8 done while idle is ignored; R6 rotation; R7 idle and mode exit
        mode_sel = 2'b11; tick();
        done_pulse(2'd0, 1'b0);
        sw_req = 4'b1111; tick();
        chk_grant("R8", 4'b0001);
        done_pulse(2'd0, 1'b0);
        sw_req = '0;
        repeat (3) tick();
        sw_req = 4'b1111; tick();
        chk_grant("R7", 4'b0010);
        done_pulse(2'd1, 1'b0);
        tick();
        chk_grant("R6", 4'b0100);
        done_pulse(2'd2, 1'b0);
        sw_req = '0; mode_sel = 2'b00; tick();
        mode_sel = 2'b11; sw_req = 4'b1111; tick();
        chk_grant("R7", 4'b0001);
        done_pulse(2'd0, 1'b0);
        sw_req = '0; mode_sel = 2'b00; tick();

        // R10 / R13: routed channel ignores direct request
        per_route = 4'b0010;
        chk(irq_mask == 4'b0010, "R10", int'(irq_mask), 2);
        sw_req = 4'b0010; tick(); tick();
        chk_grant("R13", 4'b0000);
        sw_req = '0;

        // R11: cycle steal clears on first unit
        per_irq = 4'b0010; tick();
        per_irq = '0; tick();
        chk_grant("R11", 4'b0010);
        done_pulse(2'd1, 1'b0);
        tick();
        chk_grant("R11", 4'b0000);

        // R12: burst clears only on last unit
        per_route = 4'b0100; burst_sel = 4'b0100;
        chk(irq_mask == 4'b0100, "R10", int'(irq_mask), 4);
        per_irq = 4'b0100; tick();
        per_irq = '0; tick();
        chk_grant("R12", 4'b0100);
        done_pulse(2'd2, 1'b0);
        tick();
        chk_grant("R12", 4'b0100);
        done_pulse(2'd2, 1'b1);
        tick();
        chk_grant("R12", 4'b0000);

        // R13: direct request survives completion
        per_route = '0; burst_sel = '0;
        sw_req = 4'b0001; tick();
        chk_grant("R13", 4'b0001);
        done_pulse(2'd0, 1'b1);
        tick();
        chk_grant("R13", 4'b0001);
        done_pulse(2'd0, 1'b0);
        sw_req = '0; tick();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule